// File: doc/BRIEF.md
# Boot-Configurable Clock Enable Divider

This block turns one fast input clock into two streams of single-cycle enable pulses: a core/system enable and a slower bus/flash enable. The logic downstream uses these as clock enables rather than as separate clocks. The bus/flash stage counts core enable pulses, not raw clocks, so every bus/flash enable falls on a cycle that also carries a core enable.

The core ratio at reset comes from a two-bit boot option input. The erased all-ones value of that input gives the fastest start. Any cleared bit gives a slower, lower-power start. The bus/flash ratio always resets to divide by two. After reset, software may reprogram both ratios through a one-cycle write port. While the low-power run input is high, such writes are refused and a sticky error flag is raised.

Each divider stage is a two-state machine:

- **DS_PASS** is used for a ratio of one. The enable stays high on every tick.
- **DS_COUNT** counts down to zero. It pulses the enable at zero.

The transitions are:

- **reload-to-pass**: taken at a terminal tick when the programmed field is zero.
- **reload-to-count**: taken at a terminal tick when the programmed field is non-zero.
- **count-down**: taken at a non-terminal tick, staying in DS_COUNT.

A stage picks up a new ratio only at its terminal tick.

Top module: `clkdiv_ctrl`

## Requirements
- R1: In the reset cycle the core field loads from the option bits opt_i: 2'b00 gives 7 (divide by 8), 2'b01 gives 3 (divide by 4), 2'b10 gives 1 (divide by 2), and 2'b11 gives 0 (divide by 1).
- R2: In the reset cycle the bus/flash field loads 1 (divide by 2) for every option value, and the error flag clears.
- R3: A core field value N makes core_en_o pulse exactly once every N+1 clocks. When N is 0, core_en_o stays high on every cycle.
- R4: A bus/flash field value B makes bus_en_o pulse once every B+1 core enable pulses. bus_en_o is never high unless core_en_o is high in the same cycle.
- R5: A write (wr_en_i high) while lp_run_i is low stores wr_data_i[3:0] as the core field and wr_data_i[6:4] as the bus/flash field.
- R6: A write while lp_run_i is high leaves both fields unchanged and sets the error flag.
- R7: A write while lp_run_i is low with wr_data_i[7] = 1 clears the error flag. With wr_data_i[7] = 0 the flag keeps its value.
- R8: A new ratio takes effect only at the stage's next terminal count. The period in progress at the time of the write completes with the old ratio.
- R9: Every reset discards software settings and reloads both fields from the option-selected values.
- R10: rd_data_o returns the error flag in bit 7, the bus/flash field in bits 6:4 and the core field in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Synchronous active-low system reset |
| opt_i | input | 2 | Boot option bits selecting the core reset ratio |
| lp_run_i | input | 1 | Low-power run mode; high blocks field writes |
| wr_en_i | input | 1 | One-cycle write strobe |
| wr_data_i | input | 8 | Write data: core field, bus/flash field, error clear bit |
| rd_data_o | output | 8 | Readback of the error flag and both fields |
| core_en_o | output | 1 | Core/system enable pulse |
| bus_en_o | output | 1 | Bus/flash enable pulse |

## Verification
Assertions check the following on every cycle:

- A bus/flash enable is always nested in a core enable.
- A refused write holds both fields and raises the flag.
- An error-clear write drops the flag.
- A pulse followed by a reload to a ratio above one is followed by a low cycle.

Some behaviour only the bench scenarios can show:

- The exact pulse spacing for each ratio.
- The core field loaded from each option code at reset.
- The old period completing after a mid-period write.
- Reset discarding software values.

The bench shows these by measuring gaps between pulses at the ports under directed and random ratio settings.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned CORE_W_DEF  = 4;
    localparam int unsigned BUS_W_DEF   = 3;
    localparam int unsigned OPT_W_DEF   = 2;
    localparam int unsigned BUS_RST_DEF = 1;

    // Divider stage states: ratio one passes every tick, otherwise count down.
    typedef enum logic {
        DS_PASS  = 1'b0,
        DS_COUNT = 1'b1
    } div_state_e;

endpackage

// File: rtl/clkdiv_boot_sel.sv
module clkdiv_boot_sel #(
    parameter int unsigned CORE_W = clkdiv_pkg::CORE_W_DEF,
    parameter int unsigned OPT_W  = clkdiv_pkg::OPT_W_DEF
) (
    input  logic [OPT_W-1:0]  opt_i,
    output logic [CORE_W-1:0] core_rst_o
);

    // All-ones option gives a shift of zero (ratio 1); each step down doubles the ratio.
    localparam int unsigned MAX_SHIFT = (1 << OPT_W) - 1;

    always_comb begin
        int unsigned sh;
        sh         = MAX_SHIFT - int'(opt_i);
        core_rst_o = CORE_W'((32'd1 << sh) - 32'd1);
    end

endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
    parameter int unsigned CORE_W  = clkdiv_pkg::CORE_W_DEF,
    parameter int unsigned BUS_W   = clkdiv_pkg::BUS_W_DEF,
    parameter int unsigned BUS_RST = clkdiv_pkg::BUS_RST_DEF
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [CORE_W-1:0]       core_rst_i,
    input  logic                    lp_run_i,
    input  logic                    wr_en_i,
    input  logic [CORE_W+BUS_W:0]   wr_data_i,
    output logic [CORE_W-1:0]       core_field_o,
    output logic [BUS_W-1:0]        bus_field_o,
    output logic                    err_o
);

    localparam int unsigned CLR_BIT = CORE_W + BUS_W;

    logic [CORE_W-1:0] core_q;
    logic [BUS_W-1:0]  bus_q;
    logic              err_q;
    logic              wr_ok;
    logic              wr_bad;

    always_comb begin
        wr_ok  = wr_en_i && !lp_run_i;
        wr_bad = wr_en_i &&  lp_run_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            core_q <= core_rst_i;
            bus_q  <= BUS_W'(BUS_RST);
            err_q  <= 1'b0;
        end else begin
            if (wr_ok) begin
                core_q <= wr_data_i[CORE_W-1:0];
                bus_q  <= wr_data_i[CORE_W+BUS_W-1:CORE_W];
                if (wr_data_i[CLR_BIT]) begin
                    err_q <= 1'b0;
                end
            end
            if (wr_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        core_field_o = core_q;
        bus_field_o  = bus_q;
        err_o        = err_q;
    end

    AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && lp_run_i) |=> ($stable(core_field_o) && $stable(bus_field_o))); // R6
    AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && lp_run_i) |=> err_o); // R6
    AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !lp_run_i && wr_data_i[CLR_BIT]) |=> !err_o); // R7

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int unsigned W = clkdiv_pkg::CORE_W_DEF
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [W-1:0] field_i,
    input  logic [W-1:0] rst_val_i,
    output logic         en_o
);

    import clkdiv_pkg::*;

    div_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         terminal;

    always_comb begin
        terminal = (state_q == DS_PASS) || (cnt_q == '0);
    end

    // Next-state: reload from the programmed field only at the terminal tick.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick_i) begin
            unique case (state_q)
                DS_PASS: begin
                    cnt_d   = field_i;
                    state_d = (field_i == '0) ? DS_PASS : DS_COUNT;
                end
                DS_COUNT: begin
                    if (cnt_q == '0) begin
                        cnt_d   = field_i;
                        state_d = (field_i == '0) ? DS_PASS : DS_COUNT;
                    end else begin
                        cnt_d   = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = DS_PASS;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= rst_val_i;
            state_q <= (rst_val_i == '0) ? DS_PASS : DS_COUNT;
        end else begin
            cnt_q   <= cnt_d;
            state_q <= state_d;
        end
    end

    always_comb begin
        en_o = tick_i && terminal;
    end

    AST_DIV_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && en_o && (field_i != '0)) |=> !en_o); // R3

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
    parameter int unsigned CORE_W  = clkdiv_pkg::CORE_W_DEF,
    parameter int unsigned BUS_W   = clkdiv_pkg::BUS_W_DEF,
    parameter int unsigned OPT_W   = clkdiv_pkg::OPT_W_DEF,
    parameter int unsigned BUS_RST = clkdiv_pkg::BUS_RST_DEF
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [OPT_W-1:0]      opt_i,
    input  logic                  lp_run_i,
    input  logic                  wr_en_i,
    input  logic [CORE_W+BUS_W:0] wr_data_i,
    output logic [CORE_W+BUS_W:0] rd_data_o,
    output logic                  core_en_o,
    output logic                  bus_en_o
);

    logic [CORE_W-1:0] core_rst;
    logic [CORE_W-1:0] core_field;
    logic [BUS_W-1:0]  bus_field;
    logic              err;
    logic              core_en;
    logic              bus_en;

    clkdiv_boot_sel #(.CORE_W(CORE_W), .OPT_W(OPT_W)) u_boot (
        .opt_i      (opt_i),
        .core_rst_o (core_rst)
    );

    clkdiv_regs #(.CORE_W(CORE_W), .BUS_W(BUS_W), .BUS_RST(BUS_RST)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .core_rst_i   (core_rst),
        .lp_run_i     (lp_run_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .core_field_o (core_field),
        .bus_field_o  (bus_field),
        .err_o        (err)
    );

    clkdiv_stage #(.W(CORE_W)) u_core_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (1'b1),
        .field_i   (core_field),
        .rst_val_i (core_rst),
        .en_o      (core_en)
    );

    // Bus/flash stage advances on core enables only, so its pulses nest inside them.
    clkdiv_stage #(.W(BUS_W)) u_bus_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (core_en),
        .field_i   (bus_field),
        .rst_val_i (BUS_W'(BUS_RST)),
        .en_o      (bus_en)
    );

    always_comb begin
        rd_data_o = {err, bus_field, core_field};
        core_en_o = core_en;
        bus_en_o  = bus_en;
    end

    AST_BUS_IN_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_en_o |-> core_en_o); // R4

endmodule

// File: tb/clkdiv_ctrl_tb.sv
module clkdiv_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] opt = 2'b11;
    logic       lp = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd;
    logic       core_en;
    logic       bus_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    clkdiv_ctrl u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .opt_i     (opt),
        .lp_run_i  (lp),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd),
        .core_en_o (core_en),
        .bus_en_o  (bus_en)
    );

    function automatic int boot_core(input int o);
        return (8 >> o) - 1;
    endfunction

    function automatic int word(input int e, input int b, input int c);
        return e * 128 + b * 16 + c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] o);
        opt   = o;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic wait_core();
        for (int i = 0; i < 600; i++) begin
            if (core_en) break;
            step();
        end
    endtask

    task automatic core_gap(output int g);
        wait_core();
        step();
        g = 1;
        while (!core_en && g < 600) begin
            step();
            g++;
        end
    endtask

    task automatic bus_gap(output int clocks, output int cores, output bit nested);
        for (int i = 0; i < 3000; i++) begin
            if (bus_en) break;
            step();
        end
        step();
        clocks = 1;
        cores  = core_en ? 1 : 0;
        while (!bus_en && clocks < 3000) begin
            step();
            clocks++;
            if (core_en) cores++;
        end
        nested = core_en;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int g, clk_n, core_n, cnt;
        bit nest;
        int unsigned seed_v;
        seed_v = $urandom(32'h0C1D_0B07);

        // R1 / R2 / R10: reset values for every option code
        for (int o = 0; o < 4; o++) begin
            do_reset(o[1:0]);
            check(rd == 8'(word(0, 1, boot_core(o))), "R1 R2 R10 reset readback", rd, word(0, 1, boot_core(o)));
            core_gap(g);
            check(g == boot_core(o) + 1, "R1 R3 boot core period", g, boot_core(o) + 1);
            bus_gap(clk_n, core_n, nest);
            check(core_n == 2, "R2 R4 boot bus core-pulse count", core_n, 2);
        end

        // R3: ratio one keeps core enable high
        do_reset(2'b11);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            if (core_en) cnt++;
            step();
        end
        check(cnt == 6, "R3 continuous enable at ratio one", cnt, 6);

        // R8: write mid-period; old period of 8 completes, then 2
        do_reset(2'b00);
        wait_core();
        reg_write(8'h11);
        g = 1;
        while (!core_en && g < 600) begin
            step();
            g++;
        end
        check(g == 8, "R8 old period completes", g, 8);
        step();
        g = 1;
        while (!core_en && g < 600) begin
            step();
            g++;
        end
        check(g == 2, "R8 new period after terminal", g, 2);

        // R6: write refused in low-power run
        reg_write(8'h23);
        check(rd == 8'h23, "R5 write accepted", rd, 8'h23);
        lp = 1'b1;
        reg_write(8'h75);
        lp = 1'b0;
        check(rd == 8'hA3, "R6 fields held and flag set", rd, 8'hA3);
        core_gap(g);
        core_gap(g);
        check(g == 4, "R6 ratio unchanged after refused write", g, 4);

        // R7: flag sticky without clear bit, cleared with it
        reg_write(8'h23);
        check(rd[7] == 1'b1, "R7 flag sticky", rd[7], 1);
        reg_write(8'hA3);
        check(rd == 8'h23, "R7 flag cleared", rd, 8'h23);

        // R9: reset discards software settings, even with flag set
        lp = 1'b1;
        reg_write(8'h00);
        lp = 1'b0;
        do_reset(2'b10);
        check(rd == 8'h11, "R9 reset reload", rd, 8'h11);

        // Random ratios: R3 R4 R5
        for (int it = 0; it < 30; it++) begin
            int c, b;
            c = int'($urandom % 16);
            b = int'($urandom % 8);
            if ($urandom % 4 == 0) begin
                lp = 1'b1;
                reg_write(8'(word(0, int'($urandom % 8), int'($urandom % 16))));
                lp = 1'b0;
                check(rd[7] == 1'b1, "R6 random refused write flag", rd[7], 1);
            end
            reg_write(8'(word(1, b, c)));
            check(rd == 8'(word(0, b, c)), "R5 R7 R10 random readback", rd, word(0, b, c));
            bus_gap(clk_n, core_n, nest);
            bus_gap(clk_n, core_n, nest);
            core_gap(g);
            check(g == c + 1, "R3 random core period", g, c + 1);
            bus_gap(clk_n, core_n, nest);
            check(clk_n == (c + 1) * (b + 1), "R4 random bus period", clk_n, (c + 1) * (b + 1));
            check(core_n == b + 1, "R4 core pulses per bus pulse", core_n, b + 1);
            check(nest, "R4 bus enable nested in core enable", nest, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule